// File: doc/BRIEF.md
# Debug-Mode Bus Request Arbiter

This block decides when an external bus master may take over the address and data bus while the processor sits halted in debug mode. It watches the serial debug shift engine through a small interface. The interface carries a busy flag while a byte is being shifted and a one-bit separator that follows each byte. A separator of 1 ends a debug operation. A separator of 0 announces that more read or write bytes follow.

An external master raises an asynchronous request line. Software controls a grant enable bit, which is cleared at reset. When the enable is set and the debug engine is idle, the block grants the bus. When a debug operation is in flight, a pending request is remembered and granted at the first separator of 1. The acknowledge is held until the requester lets go.

While the grant is active, a "bus granted" indication goes back to the debug engine. The engine then limits itself to internal register accesses. The current acknowledge and enable states can be read as a two-bit status word.

Top module: `dbg_bus_arb`

## Requirements
- R1: After reset `bus_ack_o`, `bus_granted_o` and both `stat_o` bits are 0. While the enable is 0, a request never produces an acknowledge.
- R2: The request input passes through a two-flop synchronizer. Consider the engine idle (not busy, and no operation left open by a separator of 0) with the enable set. A request driven between clock edges raises `bus_ack_o` on the third following rising edge.
- R3: While `shift_busy_i` is high and no separator of 1 is presented, a request is not acknowledged.
- R4: If the synchronized request is high in the same cycle that `sep_valid_i` is presented with `sep_bit_i`=1, the acknowledge rises on the next clock.
- R5: A separator with `sep_bit_i`=0 keeps the operation open. The acknowledge stays low through it and through the idle gap that follows, until a separator of 1 arrives.
- R6: A request held off during an operation is granted at the first separator of 1 without the request line being toggled.
- R7: Once asserted, the acknowledge stays high while the request stays high. It falls on the third rising edge after the request input is released, which is one cycle after the synchronized request drops.
- R8: `bus_granted_o` equals `bus_ack_o` in every cycle.
- R9: Status word `stat_o`: bit 0 is the enable bit and bit 1 mirrors the acknowledge state. A write (`cfg_we_i`=1) loads `cfg_en_i` into the enable and is visible in bit 0 on the next clock.
- R10: Clearing the enable while no grant is active blocks new grants and drops a remembered request. Clearing it during an active grant does not revoke that grant before the request is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | External bus request, asynchronous |
| cfg_we_i | input | 1 | Software write strobe for the grant enable |
| cfg_en_i | input | 1 | Value written into the grant enable |
| shift_busy_i | input | 1 | Debug engine is shifting a data byte |
| sep_valid_i | input | 1 | Separator bit is presented this cycle |
| sep_bit_i | input | 1 | Separator value, 1 = end of operation |
| bus_ack_o | output | 1 | Bus acknowledge to the external master |
| bus_granted_o | output | 1 | Tells the debug engine the bus is given away |
| stat_o | output | 2 | Status word: bit 1 acknowledge, bit 0 enable |

## Verification
The hardest case to reach is a request whose synchronized copy becomes high in exactly the cycle that a separator of 1 arrives. The stimulus keeps the engine busy and raises the request line. It waits the two synchronizer cycles and only then presents the separator. A second scenario holds a request across a separator of 0 and an idle gap, so that the grant can come only from the remembered request at the closing separator.

// File: rtl/dbg_arb_pkg.sv
package dbg_arb_pkg;
  localparam int unsigned STAT_W       = 2;
  localparam int unsigned STAT_EN_BIT  = 0;
  localparam int unsigned STAT_ACK_BIT = 1;

  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_HELD  = 2'd1,
    ARB_GRANT = 2'd2
  } arb_state_e;
endpackage

// File: rtl/dbg_arb_sync.sv
module dbg_arb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= d_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dbg_arb_op_track.sv
module dbg_arb_op_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_busy_i,
  input  logic sep_valid_i,
  input  logic sep_bit_i,
  output logic op_open_o,
  output logic idle_o,
  output logic op_done_o
);
  logic op_open_q;

  assign op_done_o = sep_valid_i & sep_bit_i;

  // operation opens on shifting, closes only on a separator of 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           op_open_q <= 1'b0;
    else if (op_done_o)    op_open_q <= 1'b0;
    else if (shift_busy_i) op_open_q <= 1'b1;
  end

  assign op_open_o = op_open_q;
  assign idle_o    = ~op_open_q & ~shift_busy_i;
endmodule

// File: rtl/dbg_arb_grant.sv
module dbg_arb_grant
  import dbg_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_we_i,
  input  logic cfg_en_i,
  input  logic req_s_i,
  input  logic idle_i,
  input  logic op_done_i,
  output logic ack_o,
  output logic en_o
);
  arb_state_e state_q, state_d;
  logic       en_q;
  logic       may_grant;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= 1'b0;
    else if (cfg_we_i) en_q <= cfg_en_i;
  end

  assign may_grant = en_q & req_s_i & (idle_i | op_done_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_IDLE, ARB_HELD: begin
        if (may_grant)            state_d = ARB_GRANT;
        else if (en_q & req_s_i)  state_d = ARB_HELD;
        else                      state_d = ARB_IDLE;
      end
      ARB_GRANT: if (!req_s_i)    state_d = ARB_IDLE;
      default:                    state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ARB_IDLE;
    else         state_q <= state_d;
  end

  assign ack_o = (state_q == ARB_GRANT);
  assign en_o  = en_q;
endmodule

// File: rtl/dbg_bus_arb.sv
module dbg_bus_arb
  import dbg_arb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              cfg_we_i,
  input  logic              cfg_en_i,
  input  logic              shift_busy_i,
  input  logic              sep_valid_i,
  input  logic              sep_bit_i,
  output logic              bus_ack_o,
  output logic              bus_granted_o,
  output logic [STAT_W-1:0] stat_o
);
  logic req_s;
  logic op_open, idle, op_done;
  logic ack, en;

  dbg_arb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bus_req_i),
    .q_o   (req_s)
  );

  dbg_arb_op_track u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_busy_i(shift_busy_i),
    .sep_valid_i (sep_valid_i),
    .sep_bit_i   (sep_bit_i),
    .op_open_o   (op_open),
    .idle_o      (idle),
    .op_done_o   (op_done)
  );

  dbg_arb_grant u_grant (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_we_i (cfg_we_i),
    .cfg_en_i (cfg_en_i),
    .req_s_i  (req_s),
    .idle_i   (idle),
    .op_done_i(op_done),
    .ack_o    (ack),
    .en_o     (en)
  );

  assign bus_ack_o     = ack;
  assign bus_granted_o = ack;

  always_comb begin
    stat_o               = '0;
    stat_o[STAT_EN_BIT]  = en;
    stat_o[STAT_ACK_BIT] = ack;
  end
endmodule

// File: rtl/dbg_bus_arb_chk.sv
module dbg_bus_arb_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_s,
  input logic       op_open,
  input logic       shift_busy_i,
  input logic       sep_valid_i,
  input logic       sep_bit_i,
  input logic       bus_ack_o,
  input logic       bus_granted_o,
  input logic [1:0] stat_o
);
  p_no_grant_disabled_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_o[0] && !bus_ack_o) |=> !bus_ack_o);

  p_busy_holds_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_ack_o && shift_busy_i && !(sep_valid_i && sep_bit_i)) |=> !bus_ack_o);

  p_sep_grant_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[0] && req_s && !bus_ack_o && sep_valid_i && sep_bit_i) |=> bus_ack_o);

  p_open_op_holds_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_ack_o && op_open && !(sep_valid_i && sep_bit_i)) |=> !bus_ack_o);

  p_hold_while_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_ack_o && req_s) |=> bus_ack_o);

  p_drop_after_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_ack_o && !req_s) |=> !bus_ack_o);

  p_granted_mirror_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_granted_o == bus_ack_o);

  p_status_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[1] == bus_ack_o);
endmodule

bind dbg_bus_arb dbg_bus_arb_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_s        (req_s),
  .op_open      (op_open),
  .shift_busy_i (shift_busy_i),
  .sep_valid_i  (sep_valid_i),
  .sep_bit_i    (sep_bit_i),
  .bus_ack_o    (bus_ack_o),
  .bus_granted_o(bus_granted_o),
  .stat_o       (stat_o)
);

// File: tb/dbg_bus_arb_test.sv
module dbg_bus_arb_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0, wen = 1'b0;
  logic       busy = 1'b0, sepv = 1'b0, sepb = 1'b0;
  logic       ack, granted;
  logic [1:0] stat;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic       ack;
    logic [1:0] stat;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  // reference state derived from the requirements
  logic m_s1 = 0, m_s2 = 0, m_open = 0, m_ack = 0, m_en = 0;

  always #4 clk = ~clk;

  dbg_bus_arb uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bus_req_i    (req),
    .cfg_we_i     (we),
    .cfg_en_i     (wen),
    .shift_busy_i (busy),
    .sep_valid_i  (sepv),
    .sep_bit_i    (sepb),
    .bus_ack_o    (ack),
    .bus_granted_o(granted),
    .stat_o       (stat)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: {ack,granted,stat} actual=%b expected=%b", tag, act, expv);
    end
  endtask

  // driver: apply one cycle of stimulus, predict the post-edge outputs
  task automatic step(input logic r, input logic b, input logic sv, input logic sb,
                      input logic w, input logic wd, input string tag);
    logic done, idle_now, grant, n_ack;
    exp_t e;
    @(negedge clk);
    req = r; busy = b; sepv = sv; sepb = sb; we = w; wen = wd;
    done     = sv & sb;
    idle_now = !m_open && !b;
    grant    = m_en && m_s2 && (idle_now || done);
    n_ack    = m_ack ? m_s2 : grant;
    m_open   = done ? 1'b0 : (b ? 1'b1 : m_open);
    m_en     = w ? wd : m_en;
    m_ack    = n_ack;
    m_s2     = m_s1;
    m_s1     = r;
    e.ack = m_ack; e.stat = {m_ack, m_en}; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk); #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, {ack, granted, stat}, {e.ack, e.ack, e.stat});
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {ack, granted, stat}, 4'b0000);
    rst_n = 1'b1;

    // R1: request with enable cleared is ignored
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, 0, "R1");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, "R1");

    // R9: enable write shows in status bit 0
    step(0, 0, 0, 0, 1, 1, "R9");
    step(0, 0, 0, 0, 0, 0, "R9");

    // R2: idle grant three edges after request; R7/R8 hold
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, "R7 R8");
    // R7: release, drop on third edge
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, "R7");

    // R3/R5/R6: request held off across busy bytes, separator 0 and gap
    step(0, 1, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 0, 0, "R3");
    step(1, 0, 1, 0, 0, 0, "R5");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, "R5");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, 0, "R3");
    step(1, 0, 1, 1, 0, 0, "R6");
    for (int i = 0; i < 2; i++) step(1, 0, 0, 0, 0, 0, "R6");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, "R7");

    // R4: synchronized request first high in the separator-1 cycle
    step(0, 1, 0, 0, 0, 0, "R4");
    step(1, 1, 0, 0, 0, 0, "R4");
    step(1, 1, 0, 0, 0, 0, "R4");
    step(1, 0, 1, 1, 0, 0, "R4");
    step(1, 0, 0, 0, 0, 0, "R4");
    step(1, 0, 0, 0, 0, 0, "R4");

    // R10: clearing the enable mid-grant keeps the grant
    step(1, 0, 0, 0, 1, 0, "R10");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, "R10");
    // R10: disabled while idle, new request blocked
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, 0, "R10");
    // R10: remembered request dropped when enable cleared
    step(0, 0, 0, 0, 1, 1, "R10");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, "R10");
    step(0, 1, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, 0, "R10");
    step(1, 1, 0, 0, 1, 0, "R10");
    step(1, 0, 1, 1, 0, 0, "R10");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, "R1");

    repeat (3) @(posedge clk);
    #3;
    finish_run();
  end
endmodule